// File: doc/BRIEF.md
# Branch-on-Index Execution Unit

This unit carries out the two loop-closing branches of a 32-bit register-indexed processor. Each one adds an increment to an index register, compares the new index with a limit, and reports whether the loop branch is taken. One opcode takes the branch while the new index is at or below the limit, so the loop counts up. The other takes the branch while the new index is above the limit, so the loop counts down. The increment comes from the even register of an even/odd pair and the limit comes from the odd register. The updated index is written back to the index register.

The unit sits beside a 16 x 32-bit general register file and uses three combinational read ports on it. On the cycle that `start_i` is high, it reads the index register, the increment and the limit on those ports. On the following cycle it reads the base register on port 0. In that same cycle it presents the write-back, the taken flag, the 24-bit branch target and a one-cycle `done_o` pulse. Any other opcode produces a `done_o` pulse with `illegal_o` set, and no register is written.

Top module: `idx_branch_unit`

## Requirements
- R1: Bits 31:24 of the instruction select the operation: 0x87 is the low-or-equal variant and 0x86 is the high variant. Any other value gives `done_o` with `illegal_o`=1, `wb_en_o`=0 and `taken_o`=0.
- R2: The instruction fields are: index register number at bits 23:20, pair register number at bits 19:16, base register number at bits 15:12, and a 12-bit displacement at bits 11:0. In the start cycle, port 0 reads the index register, port 1 reads the pair register, and port 2 reads the pair register with bit 0 forced to 1.
- R3: The write-back value is the index plus the increment, modulo 2^32, with no overflow indication. It is written to the index register number.
- R4: For 0x87, `taken_o` is 1 exactly when the new index, taken as a signed two's-complement value, is less than or equal to the signed limit.
- R5: For 0x86, `taken_o` is 1 exactly when the signed new index is strictly greater than the signed limit.
- R6: When the pair register number is odd, that single register supplies both the increment and the limit.
- R7: All operands are read before the write-back. The result is therefore defined when the index register is also the increment register or the limit register.
- R8: `target_o` is the low 24 bits of the zero-extended displacement plus the base register's contents. A base register number of 0 contributes zero. The base register is read on port 0 during the done cycle, before that cycle's write-back lands.
- R9: `done_o`, `wb_en_o`, `taken_o`, `illegal_o` and `target_o` are valid for exactly one cycle, the cycle after `start_i`. A `start_i` that arrives during the done cycle is ignored.
- R10: During and after reset, with no start, `done_o`, `wb_en_o`, `taken_o` and `illegal_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, one cycle |
| insn_i | input | 32 | Instruction word, sampled with start |
| rd0_addr_o | output | 4 | Read port 0 address (index, then base) |
| rd0_data_i | input | 32 | Read port 0 data |
| rd1_addr_o | output | 4 | Read port 1 address (increment) |
| rd1_data_i | input | 32 | Read port 1 data |
| rd2_addr_o | output | 4 | Read port 2 address (limit) |
| rd2_data_i | input | 32 | Read port 2 data |
| wb_en_o | output | 1 | Register write enable |
| wb_addr_o | output | 4 | Register write address |
| wb_data_o | output | 32 | Register write data (new index) |
| taken_o | output | 1 | Branch taken |
| target_o | output | 24 | Branch target address |
| illegal_o | output | 1 | Opcode not handled |
| done_o | output | 1 | Completion pulse |

## Verification
The assertions assume that the register file returns read data in the same cycle as the address, and that its contents do not change between the start cycle and the done cycle other than through this unit's own write-back. The bench register model meets these assumptions: reads are combinational, the only writes come from `wb_en_o` at a clock edge, and directly preloaded values are set only between operations. Starts are driven at least two cycles apart, except in one deliberate start issued during a done cycle, which checks that such a start is ignored.

// File: rtl/idx_branch_unit.sv
module idx_branch_unit #(
  parameter int XLEN = 32,
  parameter int TW   = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [31:0]     insn_i,
  output logic [3:0]      rd0_addr_o,
  input  logic [XLEN-1:0] rd0_data_i,
  output logic [3:0]      rd1_addr_o,
  input  logic [XLEN-1:0] rd1_data_i,
  output logic [3:0]      rd2_addr_o,
  input  logic [XLEN-1:0] rd2_data_i,
  output logic            wb_en_o,
  output logic [3:0]      wb_addr_o,
  output logic [XLEN-1:0] wb_data_o,
  output logic            taken_o,
  output logic [TW-1:0]   target_o,
  output logic            illegal_o,
  output logic            done_o
);
  localparam logic [7:0] OP_LE = 8'h87;
  localparam logic [7:0] OP_HI = 8'h86;
  localparam int DW = 12;

  logic            busy_q, legal_q, taken_q;
  logic [XLEN-1:0] sum_q;
  logic [3:0]      r1_q, b2_q;
  logic [DW-1:0]   d2_q;

  logic [7:0]      op;
  logic [3:0]      f_r1, f_r3, f_b2;
  logic            is_le, is_hi, accept, above;
  logic [XLEN-1:0] sum, base, tgt_full;

  assign op     = insn_i[31:24];
  assign f_r1   = insn_i[23:20];
  assign f_r3   = insn_i[19:16];
  assign f_b2   = insn_i[15:12];
  assign is_le  = (op == OP_LE);
  assign is_hi  = (op == OP_HI);
  assign accept = start_i && !busy_q;

  assign rd0_addr_o = busy_q ? b2_q : f_r1;
  assign rd1_addr_o = f_r3;
  assign rd2_addr_o = {f_r3[3:1], 1'b1};

  assign sum   = rd0_data_i + rd1_data_i;
  assign above = $signed(sum) > $signed(rd2_data_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      legal_q <= 1'b0;
      taken_q <= 1'b0;
      sum_q   <= '0;
      r1_q    <= '0;
      b2_q    <= '0;
      d2_q    <= '0;
    end else begin
      busy_q <= accept;
      if (accept) begin
        legal_q <= is_le || is_hi;
        taken_q <= (is_le && !above) || (is_hi && above);
        sum_q   <= sum;
        r1_q    <= f_r1;
        b2_q    <= f_b2;
        d2_q    <= insn_i[DW-1:0];
      end
    end
  end

  assign base     = (b2_q == 4'd0) ? '0 : rd0_data_i;
  assign tgt_full = base + {{(XLEN-DW){1'b0}}, d2_q};

  assign done_o    = busy_q;
  assign wb_en_o   = busy_q && legal_q;
  assign wb_addr_o = r1_q;
  assign wb_data_o = sum_q;
  assign taken_o   = busy_q && taken_q;
  assign illegal_o = busy_q && !legal_q;
  assign target_o  = busy_q ? tgt_full[TW-1:0] : '0;

  AST_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> done_o); // R9
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_le && !is_hi) |=> (illegal_o && !wb_en_o && !taken_o)); // R1
  AST_SUM_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (is_le || is_hi)) |=>
      (wb_en_o && wb_data_o == $past(rd0_data_i + rd1_data_i)
       && wb_addr_o == $past(insn_i[23:20]))); // R3
  AST_LE_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_le) |=>
      (taken_o == ($signed(wb_data_o) <= $signed($past(rd2_data_i))))); // R4
  AST_HI_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_hi) |=>
      (taken_o == ($signed(wb_data_o) > $signed($past(rd2_data_i))))); // R5
endmodule

// File: tb/tb_idx_branch_unit.sv
module tb_idx_branch_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [3:0]  rd0_addr_o, rd1_addr_o, rd2_addr_o, wb_addr_o;
  logic [31:0] rd0_data_i, rd1_data_i, rd2_data_i, wb_data_o;
  logic        wb_en_o, taken_o, illegal_o, done_o;
  logic [23:0] target_o;

  logic [31:0] rf [16];
  int total = 0;
  int bad = 0;

  typedef struct packed {
    logic        wb;
    logic [3:0]  a;
    logic [31:0] d;
    logic        tk;
    logic [23:0] tg;
    logic        ill;
  } exp_t;
  exp_t q[$];
  string tagq[$];

  always #4 clk = ~clk;

  assign rd0_data_i = rf[rd0_addr_o];
  assign rd1_data_i = rf[rd1_addr_o];
  assign rd2_data_i = rf[rd2_addr_o];

  always @(posedge clk) if (wb_en_o) rf[wb_addr_o] <= wb_data_o;

  idx_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
    .rd0_addr_o(rd0_addr_o), .rd0_data_i(rd0_data_i),
    .rd1_addr_o(rd1_addr_o), .rd1_data_i(rd1_data_i),
    .rd2_addr_o(rd2_addr_o), .rd2_data_i(rd2_data_i),
    .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o),
    .taken_o(taken_o), .target_o(target_o), .illegal_o(illegal_o),
    .done_o(done_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] op, input logic [3:0] r1,
                                     input logic [3:0] r3, input logic [3:0] b2,
                                     input logic [11:0] d2);
    return {op, r1, r3, b2, d2};
  endfunction

  function automatic exp_t model(input logic [31:0] w);
    exp_t e;
    logic [31:0] inc, lim, nv, bs;
    logic [3:0] p;
    logic le, hi;
    le  = (w[31:24] == 8'h87);
    hi  = (w[31:24] == 8'h86);
    p   = w[19:16];
    inc = rf[p];
    lim = rf[{p[3:1], 1'b1}];
    nv  = rf[w[23:20]] + inc;
    bs  = (w[15:12] == 4'd0) ? 32'd0 : rf[w[15:12]];
    e.ill = !(le || hi);
    e.wb  = le || hi;
    e.a   = w[23:20];
    e.d   = nv;
    e.tk  = (le && ($signed(nv) <= $signed(lim))) || (hi && ($signed(nv) > $signed(lim)));
    e.tg  = bs[23:0] + {12'd0, w[11:0]};
    return e;
  endfunction

  task automatic issue(input logic [31:0] w, input string tag);
    @(negedge clk);
    q.push_back(model(w));
    tagq.push_back(tag);
    insn_i  = w;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // monitor: compare results as they appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done_o) begin
        if (q.size() == 0) begin
          check(1'b0, "R9", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          string t;
          e = q.pop_front();
          t = tagq.pop_front();
          if (e.wb) begin
            check(wb_data_o == e.d, t, "wb_data", wb_data_o, e.d);
            check(wb_addr_o == e.a, t, "wb_addr", {28'd0, wb_addr_o}, {28'd0, e.a});
          end
          check(wb_en_o == e.wb, t, "wb_en", {31'd0, wb_en_o}, {31'd0, e.wb});
          check(taken_o == e.tk, t, "taken", {31'd0, taken_o}, {31'd0, e.tk});
          check(illegal_o == e.ill, t, "illegal", {31'd0, illegal_o}, {31'd0, e.ill});
          if (!e.ill) check(target_o == e.tg, t, "target", {8'd0, target_o}, {8'd0, e.tg});
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    check(1'b0, "R9", "watchdog expired", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'd0;
    repeat (3) @(negedge clk);
    // R10: quiet in reset
    check(!done_o && !wb_en_o && !taken_o && !illegal_o, "R10", "reset outputs",
          {28'd0, done_o, wb_en_o, taken_o, illegal_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done_o && !wb_en_o, "R10", "idle after reset", {31'd0, done_o}, 32'd0);

    // R5: counting down, high variant
    rf[4] = 4; rf[6] = 12; rf[8] = -32'sd4; rf[9] = 0; rf[12] = 32'h0000_1000;
    issue(mk(8'h86, 4'd4, 4'd8, 4'd12, 12'h123), "R5");
    issue(mk(8'h86, 4'd6, 4'd8, 4'd12, 12'h123), "R5");
    // R4: low-or-equal variant
    rf[4] = 26; rf[6] = 62; rf[8] = 1; rf[9] = 40;
    issue(mk(8'h87, 4'd4, 4'd8, 4'd0, 12'h234), "R4");
    issue(mk(8'h87, 4'd6, 4'd8, 4'd0, 12'h234), "R4");
    // R4: equality taken
    rf[4] = 39;
    issue(mk(8'h87, 4'd4, 4'd8, 4'd0, 12'h001), "R4");
    // R5: equality not taken
    rf[4] = 39;
    issue(mk(8'h86, 4'd4, 4'd8, 4'd0, 12'h001), "R5");
    // R4 R5: signed compare with negative index
    rf[2] = 0; rf[10] = -32'sd1; rf[11] = 5;
    issue(mk(8'h86, 4'd2, 4'd10, 4'd0, 12'h010), "R5");
    rf[2] = 0;
    issue(mk(8'h87, 4'd2, 4'd10, 4'd0, 12'h010), "R4");
    // R3: wrap modulo 2^32
    rf[3] = 32'h7FFF_FFFF; rf[10] = 1; rf[11] = 0;
    issue(mk(8'h87, 4'd3, 4'd10, 4'd0, 12'h000), "R3");
    // R6: odd pair register
    rf[5] = 10; rf[9] = 3;
    issue(mk(8'h86, 4'd5, 4'd9, 4'd0, 12'h000), "R6");
    // R7: index register is the increment register
    rf[8] = 7; rf[9] = 20;
    issue(mk(8'h87, 4'd8, 4'd8, 4'd0, 12'h000), "R7");
    // R7: index register is the limit register
    rf[8] = 5; rf[9] = 20;
    issue(mk(8'h86, 4'd9, 4'd8, 4'd0, 12'h000), "R7");
    // R8: target truncation with nonzero base
    rf[12] = 32'h12FF_FFF0;
    issue(mk(8'h87, 4'd1, 4'd8, 4'd12, 12'h020), "R8");
    // R8: base is the index register, old value used
    rf[1] = 32'h0000_0100; rf[8] = 4; rf[9] = 0;
    issue(mk(8'h86, 4'd1, 4'd8, 4'd1, 12'h00F), "R8");
    // R1: illegal opcode, no write
    rf[7] = 32'h55;
    issue(mk(8'h5A, 4'd7, 4'd8, 4'd0, 12'h000), "R1");
    @(negedge clk);
    check(rf[7] == 32'h55, "R1", "reg unchanged", rf[7], 32'h55);
    // R2: field positions, full loop of 20 fullword steps
    rf[10] = 0; rf[8] = 4; rf[9] = 76;
    for (int k = 0; k < 20; k++) issue(mk(8'h87, 4'd10, 4'd8, 4'd0, 12'h100), "R2");
    @(negedge clk);
    check(rf[10] == 80, "R2", "loop final index", rf[10], 32'd80);
    // R9: start during done cycle is ignored
    rf[4] = 1; rf[8] = 1;
    @(negedge clk);
    q.push_back(model(mk(8'h87, 4'd4, 4'd8, 4'd0, 12'h000)));
    tagq.push_back("R9");
    insn_i = mk(8'h87, 4'd4, 4'd8, 4'd0, 12'h000);
    start_i = 1'b1;
    @(negedge clk);
    insn_i = mk(8'h87, 4'd5, 4'd8, 4'd0, 12'h000);
    @(negedge clk);
    start_i = 1'b0;
    check(!done_o, "R9", "second start ignored", {31'd0, done_o}, 32'd0);
    repeat (2) @(negedge clk);
    check(q.size() == 0, "R9", "all results seen", q.size(), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule